// File: doc/BRIEF.md
# Baud and Oversample Tick Generator

This block turns a free-running system clock into two single-cycle enable strobes for a serial link. `baud_tick` pulses once per bit period and paces a transmitter. `os_tick` pulses a fixed number of times per bit period and paces a receiver that samples the line several times per bit. Both divisors are fixed when the block is elaborated. They come from three parameters: the clock frequency, the baud rate and the oversampling factor. Nothing can be changed at run time.

The oversample divider is forced back to zero on every baud tick, and it also strobes on that cycle. The oversample grid is therefore re-anchored to the transmit bit boundary once per bit. Rounding error in the oversample divisor can never carry from one bit period into the next. A consumer only counts strobes. There is no data path, so the block has no valid/ready interface. Both outputs are plain strobes with no back-pressure.

Top module: `baud_os_tick_gen`

## Requirements
- R1: `baud_tick` is high on exactly one cycle in every BAUD_DIV cycles, where BAUD_DIV is CLK_HZ/BAUD_RATE rounded to the nearest integer (2604 for the defaults). The first pulse is visible in the cycle after the BAUD_DIV-th rising edge following reset release.
- R2: `baud_tick` never stays high for two consecutive cycles.
- R3: Within a bit period, `os_tick` pulses every OS_DIV cycles, where OS_DIV is CLK_HZ/(BAUD_RATE*OSR) rounded to the nearest integer (163 for the defaults). The first pulse of a period comes OS_DIV cycles after that period starts.
- R4: On the cycle a baud tick fires, the oversample counter restarts from zero instead of continuing. The next `os_tick` therefore follows the baud tick by exactly OS_DIV cycles, whatever phase the counter had reached.
- R5: `os_tick` is high on every cycle on which `baud_tick` is high.
- R6: While the synchronous reset `rst` is high, both strobes are low after each clock edge. After reset is released, counting starts from zero, including after a reset in mid-run.
- R7: The bit period obtained differs from the ideal CLK_HZ/BAUD_RATE by less than one system clock period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, free-running |
| rst | input | 1 | Synchronous reset, active high |
| baud_tick | output | 1 | One-cycle strobe at the baud rate |
| os_tick | output | 1 | One-cycle strobe at the oversampling rate, re-aligned on each baud tick |

## Verification
Three configurations run side by side from one clock. The first uses the default rates. Its oversample divisor rounds up, so sixteen oversample slots would overrun a bit period, and only the forced restart on the baud tick keeps the grid aligned. The second divides evenly, so the last oversample slot and the baud tick coincide naturally. A stored table of that cycle pattern separates correct coincidence from an off-by-one. The third has oversample slots that fall short of the bit period, so a missing restart would show up as a misplaced strobe right after each baud tick. A reset asserted in mid-run checks that both counters resume from zero.

// File: rtl/baud_tick_pkg.sv
package baud_tick_pkg;

  // Nearest-integer division, halves rounded up.
  function automatic int unsigned round_div(int unsigned num, int unsigned den);
    return (2 * num + den) / (2 * den);
  endfunction

  // Counter width able to hold 0 .. div-1, never below one bit.
  function automatic int unsigned cnt_width(int unsigned div);
    return (div > 2) ? $clog2(div) : 1;
  endfunction

endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic wrap_o,
  output logic tick_o
);
  import baud_tick_pkg::*;

  localparam int unsigned W = cnt_width(DIV);
  localparam logic [W-1:0] LAST = W'(DIV - 1);

  logic [W-1:0] count_q;

  assign wrap_o = (count_q == LAST);

  // A restart request and a natural wrap both reload zero and emit a strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      tick_o  <= 1'b0;
    end else begin
      tick_o <= wrap_o | restart;
      if (wrap_o || restart) count_q <= '0;
      else                   count_q <= count_q + 1'b1;
    end
  end

endmodule

// File: rtl/baud_os_tick_gen.sv
module baud_os_tick_gen #(
  parameter int unsigned CLK_HZ    = 50_000_000,
  parameter int unsigned BAUD_RATE = 19200,
  parameter int unsigned OSR       = 16
) (
  input  logic clk,
  input  logic rst,
  output logic baud_tick,
  output logic os_tick
);
  import baud_tick_pkg::*;

  localparam int unsigned BAUD_DIV = round_div(CLK_HZ, BAUD_RATE);
  localparam int unsigned OS_DIV   = round_div(CLK_HZ, BAUD_RATE * OSR);

  logic baud_wrap;
  logic os_wrap_unused;

  tick_divider #(.DIV(BAUD_DIV)) u_baud_div (
    .clk     (clk),
    .rst     (rst),
    .restart (1'b0),
    .wrap_o  (baud_wrap),
    .tick_o  (baud_tick)
  );

  // Oversample divider is slaved to the baud boundary.
  tick_divider #(.DIV(OS_DIV)) u_os_div (
    .clk     (clk),
    .rst     (rst),
    .restart (baud_wrap),
    .wrap_o  (os_wrap_unused),
    .tick_o  (os_tick)
  );

endmodule

// File: rtl/baud_os_tick_chk.sv
module baud_os_tick_chk #(
  parameter int unsigned BAUD_DIV = 4,
  parameter int unsigned OS_DIV   = 2
) (
  input logic clk,
  input logic rst,
  input logic baud_tick,
  input logic os_tick
);
  // Cycles since the last strobe, counted from 1 just after a strobe.
  int unsigned baud_gap_q;
  int unsigned os_gap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      baud_gap_q <= 0;
      os_gap_q   <= 0;
    end else begin
      baud_gap_q <= baud_tick ? 1 : baud_gap_q + 1;
      os_gap_q   <= os_tick   ? 1 : os_gap_q + 1;
    end
  end

  assert_baud_period_R1: assert property (@(posedge clk) disable iff (rst)
    baud_tick |-> (baud_gap_q == BAUD_DIV));

  assert_baud_no_late_R1: assert property (@(posedge clk) disable iff (rst)
    baud_gap_q <= BAUD_DIV);

  assert_baud_single_R2: assert property (@(posedge clk) disable iff (rst)
    baud_tick |=> !baud_tick);

  assert_os_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    (os_tick && !baud_tick) |-> (os_gap_q == OS_DIV));

  assert_os_no_late_R4: assert property (@(posedge clk) disable iff (rst)
    os_gap_q <= OS_DIV);

  assert_os_with_baud_R5: assert property (@(posedge clk) disable iff (rst)
    baud_tick |-> os_tick);

endmodule

bind baud_os_tick_gen baud_os_tick_chk #(
  .BAUD_DIV (BAUD_DIV),
  .OS_DIV   (OS_DIV)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .baud_tick (baud_tick),
  .os_tick   (os_tick)
);

// File: tb/baud_os_tick_gen_bench.sv
module baud_os_tick_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEF_BD = 2604;  // 50e6/19200 = 2604.17 -> 2604
  localparam int DEF_OD = 163;   // 50e6/307200 = 162.76 -> 163
  localparam int ODD_BD = 9;     // 900/100
  localparam int ODD_OD = 2;     // 900/400 = 2.25 -> 2
  localparam int SML_BD = 12;    // 1200/100, 1200/400 = 3

  // {baud, os} per cycle index within a 12-cycle bit period
  localparam logic [1:0] SMALL_TBL [SML_BD] = '{
    2'b00, 2'b00, 2'b01, 2'b00, 2'b00, 2'b01,
    2'b00, 2'b00, 2'b01, 2'b00, 2'b00, 2'b11
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic def_baud, def_os, sml_baud, sml_os, odd_baud, odd_os;

  baud_os_tick_gen u_baud_os_tick_gen (
    .clk(clk), .rst(rst), .baud_tick(def_baud), .os_tick(def_os));

  baud_os_tick_gen #(.CLK_HZ(1200), .BAUD_RATE(100), .OSR(4)) u_baud_os_tick_gen_sml (
    .clk(clk), .rst(rst), .baud_tick(sml_baud), .os_tick(sml_os));

  baud_os_tick_gen #(.CLK_HZ(900), .BAUD_RATE(100), .OSR(4)) u_baud_os_tick_gen_odd (
    .clk(clk), .rst(rst), .baud_tick(odd_baud), .os_tick(odd_os));

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [1:0] model(input int e, input int bd, input int od);
    int  j;
    logic b;
    j = (e - 1) % bd;
    b = (j == bd - 1);
    return {b, b || ((j % od) == od - 1)};
  endfunction

  // Walk n edges after reset release; e counts edges from 1.
  task automatic run(input int n);
    int last_def = 0;
    logic prev_sml = 1'b0;
    for (int e = 1; e <= n; e++) begin
      logic [1:0] m;
      @(posedge clk);
      @(negedge clk);
      m = SMALL_TBL[(e - 1) % SML_BD];
      chk("R2 small baud", sml_baud, m[1]);
      chk("R5 small os", sml_os, m[0]);
      if (prev_sml) chk("R2 no repeat", sml_baud, 0);
      prev_sml = sml_baud;
      m = model(e, ODD_BD, ODD_OD);
      chk("R1 odd baud", odd_baud, m[1]);
      chk("R4 odd os", odd_os, m[0]);
      m = model(e, DEF_BD, DEF_OD);
      chk("R1 default baud", def_baud, m[1]);
      chk("R3 default os", def_os, m[0]);
      if (def_baud) begin
        if (last_def > 0) begin
          int err;
          err = (e - last_def) * 19200 - 50_000_000;
          if (err < 0) err = -err;
          chk("R7 period error below one clock", int'(err < 19200), 1);
        end
        last_def = e;
      end
    end
  endtask

  task automatic hold_reset(input int n);
    rst = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R6 reset baud", def_baud | sml_baud | odd_baud, 0);
      chk("R6 reset os", def_os | sml_os | odd_os, 0);
    end
    rst = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    hold_reset(4);
    run(3 * DEF_BD + 5);
    hold_reset(3);          // mid-run reset: counting resumes from zero (R6)
    run(40);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule